// File: doc/BRIEF.md
# Bulk Command Register Decoder

This block takes a byte stream of bulk display-controller commands over a byte-wide valid/ready input. Every command opens with the prefix byte 0xAF and a one-byte command code. Register-write commands update a bank of 8-bit video registers, and copy commands are framed and skipped. The block is always ready. It presents the active register bank, plus the multi-byte fields a scan-out engine needs: a big-endian 16-bit horizontal pixel count, a little-endian 16-bit pixel clock in 5 kHz units, and two 24-bit framebuffer base pointers.

The block supports a staged update so that a whole video mode can change at once. Writing the lock value to the control index sends later bank writes to shadow storage only. Writing the unlock value to the same index copies every shadow byte to the active outputs in a single clock edge. A non-prefix byte where a command should start sets a sticky error and is dropped, and parsing resumes at the next prefix. An unknown command code is handled the same way.

Top module: `bulk_cmd_decoder`

## Requirements
- R1: After reset all active registers read 0x00, except the blank-mode register (index 0x1F), which reads 0x01 (blanked). err_o and locked_o are 0, and ready_o is 1.
- R2: A register write is the four accepted bytes 0xAF, 0x20, index, value. When the bank is unlocked, the register at that index shows the value from the cycle after the value byte is accepted.
- R3: Writing 0x00 to control index 0xFF sets locked_o. While locked, register writes leave every output unchanged.
- R4: Writing 0xFF to index 0xFF clears locked_o. Every value written while the bank was locked appears on the outputs together, in the cycle after that value byte, and not before.
- R5: h_pixels_o takes its high byte from index 0x0F and its low byte from index 0x10.
- R6: pix_clk_o takes its low byte from index 0x1B and its high byte from index 0x1C.
- R7: base16_o is indices 0x20, 0x21, 0x22, and base8_o is indices 0x26, 0x27, 0x28. In each pointer the lowest index holds the most significant byte.
- R8: A copy command is 0xAF, 0x6A and seven argument bytes. Its arguments change no register, whatever their values, and the command that follows is decoded normally.
- R9: A prefix that is followed directly by another prefix is padding. It raises no error and does not disturb the next command.
- R10: A byte other than 0xAF at a command start sets err_o, which stays set until reset. The byte is dropped, and decoding resumes at the next 0xAF.
- R11: A command code other than 0x20, 0x6A or 0xAF sets err_o, and the parser returns to waiting for a prefix.
- R12: Writes to indices from 0x40 up to 0xFE have no effect on any output.
- R13: Bytes presented while valid_i is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Command stream byte |
| valid_i | input | 1 | byte_i holds a byte |
| ready_o | output | 1 | Always 1 |
| regs_o | output | 512 | Active register bank; register k is at bits [8k+7:8k] |
| h_pixels_o | output | 16 | Horizontal pixel count |
| pix_clk_o | output | 16 | Pixel clock in 5 kHz units |
| base16_o | output | 24 | Base pointer of the 16 bpp segment |
| base8_o | output | 24 | Base pointer of the 8 bpp segment |
| blank_mode_o | output | 8 | Blank-mode register |
| locked_o | output | 1 | Staged update open |
| err_o | output | 1 | Sticky framing error |

## Verification
The hardest state to reach from the ports is a locked bank whose shadow differs from the active copy in many places at once, followed by an unlock. Only then does a commit that copies stale or partial data become visible. Directed sequences stage several timing and pointer bytes under lock. They check the outputs after the unlock command's index byte has been accepted but before its value byte, and again one edge later. A seeded random run then mixes lock, unlock, ignored control values, out-of-range indices, copies whose payload holds prefix and write codes, padding, and idle gaps, and compares against a bench model after each group of commands.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam logic [7:0] PREFIX = 8'hAF;
  localparam int COPY_ARGS = 7;
  localparam int CNT_W = $clog2(COPY_ARGS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CODE,
    ST_IDX,
    ST_VAL,
    ST_COPY
  } pst_e;
endpackage

// File: rtl/bcd_parser.sv
module bcd_parser
  import bcd_pkg::*;
#(
  parameter logic [7:0] CMD_WR   = 8'h20,
  parameter logic [7:0] CMD_COPY = 8'h6A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       fire_i,
  output logic       wr_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_val_o,
  output logic       err_o
);
  pst_e             st_q;
  logic [7:0]       idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (fire_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (byte_i == PREFIX) st_q <= ST_CODE;
          else                  err_q <= 1'b1;  // drop, keep hunting
        end
        ST_CODE: begin
          if (byte_i == CMD_WR) st_q <= ST_IDX;
          else if (byte_i == CMD_COPY) begin
            st_q  <= ST_COPY;
            cnt_q <= '0;
          end else if (byte_i == PREFIX) st_q <= ST_CODE;  // padding prefix
          else begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_IDX: begin
          idx_q <= byte_i;
          st_q  <= ST_VAL;
        end
        ST_VAL:  st_q <= ST_IDLE;
        ST_COPY: begin
          if (cnt_q == CNT_W'(COPY_ARGS - 1)) st_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_o     = fire_i && (st_q == ST_VAL);
  assign wr_idx_o = idx_q;
  assign wr_val_o = byte_i;
  assign err_o    = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_junk_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && st_q == ST_IDLE && byte_i != PREFIX) |=> err_q);
  assert_pad_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && st_q == ST_CODE && byte_i == PREFIX) |=> (st_q == ST_CODE && $stable(err_q)));
  assert_badcode_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && st_q == ST_CODE && byte_i != PREFIX && byte_i != CMD_WR && byte_i != CMD_COPY)
      |=> (err_q && st_q == ST_IDLE));
endmodule

// File: rtl/bcd_bank.sv
module bcd_bank #(
  parameter int         NREG       = 64,
  parameter logic [7:0] CTL_IDX    = 8'hFF,
  parameter logic [7:0] LOCK_VAL   = 8'h00,
  parameter logic [7:0] UNLOCK_VAL = 8'hFF,
  parameter int         BLANK_IDX  = 31,
  parameter logic [7:0] BLANK_RST  = 8'h01
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           idx_i,
  input  logic [7:0]           val_i,
  output logic [NREG-1:0][7:0] act_o,
  output logic                 lock_o
);
  localparam int AW = $clog2(NREG);
  localparam logic [8:0] NREG9 = NREG[8:0];

  function automatic logic [NREG-1:0][7:0] rst_img();
    logic [NREG-1:0][7:0] img;
    for (int k = 0; k < NREG; k++) img[k] = (k == BLANK_IDX) ? BLANK_RST : 8'h00;
    return img;
  endfunction

  logic [NREG-1:0][7:0] act_q, sh_q;
  logic                 lock_q;
  logic                 wr_bank, wr_ctl, do_lock, do_unlock;
  logic [AW-1:0]        slot;

  assign slot      = idx_i[AW-1:0];
  assign wr_bank   = wr_i && ({1'b0, idx_i} < NREG9);
  assign wr_ctl    = wr_i && (idx_i == CTL_IDX);
  assign do_lock   = wr_ctl && (val_i == LOCK_VAL);
  assign do_unlock = wr_ctl && (val_i == UNLOCK_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= rst_img();
      sh_q   <= rst_img();
      lock_q <= 1'b0;
    end else begin
      if (wr_bank) begin
        sh_q[slot] <= val_i;
        if (!lock_q) act_q[slot] <= val_i;
      end
      if (do_lock) lock_q <= 1'b1;
      if (do_unlock) begin
        lock_q <= 1'b0;
        act_q  <= sh_q;  // whole staged image in one edge
      end
    end
  end

  assign act_o  = act_q;
  assign lock_o = lock_q;

  assert_open_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bank && !lock_q) |=> act_q[$past(slot)] == $past(val_i));
  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !do_unlock) |=> $stable(act_q));
  assert_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_unlock |=> (act_q == $past(sh_q) && !lock_q));
  assert_lock_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_lock && !do_unlock) |=> lock_q);
endmodule

// File: rtl/bcd_fields.sv
module bcd_fields #(
  parameter int NREG      = 64,
  parameter int HPIX_IDX  = 15,
  parameter int PCLK_IDX  = 27,
  parameter int B16_IDX   = 32,
  parameter int B8_IDX    = 38,
  parameter int BLANK_IDX = 31
) (
  input  logic [NREG-1:0][7:0] act_i,
  output logic [15:0]          h_pixels_o,
  output logic [15:0]          pix_clk_o,
  output logic [23:0]          base16_o,
  output logic [23:0]          base8_o,
  output logic [7:0]           blank_mode_o
);
  assign h_pixels_o   = {act_i[HPIX_IDX], act_i[HPIX_IDX+1]};
  assign pix_clk_o    = {act_i[PCLK_IDX+1], act_i[PCLK_IDX]};  // low byte first
  assign base16_o     = {act_i[B16_IDX], act_i[B16_IDX+1], act_i[B16_IDX+2]};
  assign base8_o      = {act_i[B8_IDX], act_i[B8_IDX+1], act_i[B8_IDX+2]};
  assign blank_mode_o = act_i[BLANK_IDX];
endmodule

// File: rtl/bulk_cmd_decoder.sv
module bulk_cmd_decoder #(
  parameter int         NREG       = 64,
  parameter logic [7:0] CMD_WR     = 8'h20,
  parameter logic [7:0] CMD_COPY   = 8'h6A,
  parameter logic [7:0] CTL_IDX    = 8'hFF,
  parameter logic [7:0] LOCK_VAL   = 8'h00,
  parameter logic [7:0] UNLOCK_VAL = 8'hFF,
  parameter int         BLANK_IDX  = 31,
  parameter logic [7:0] BLANK_RST  = 8'h01,
  parameter int         HPIX_IDX   = 15,
  parameter int         PCLK_IDX   = 27,
  parameter int         B16_IDX    = 32,
  parameter int         B8_IDX     = 38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [NREG*8-1:0] regs_o,
  output logic [15:0]       h_pixels_o,
  output logic [15:0]       pix_clk_o,
  output logic [23:0]       base16_o,
  output logic [23:0]       base8_o,
  output logic [7:0]        blank_mode_o,
  output logic              locked_o,
  output logic              err_o
);
  logic                 wr;
  logic [7:0]           wr_idx, wr_val;
  logic [NREG-1:0][7:0] act;

  assign ready_o = 1'b1;

  bcd_parser #(.CMD_WR(CMD_WR), .CMD_COPY(CMD_COPY)) u_parser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byte_i   (byte_i),
    .fire_i   (valid_i),
    .wr_o     (wr),
    .wr_idx_o (wr_idx),
    .wr_val_o (wr_val),
    .err_o    (err_o)
  );

  bcd_bank #(
    .NREG(NREG), .CTL_IDX(CTL_IDX), .LOCK_VAL(LOCK_VAL), .UNLOCK_VAL(UNLOCK_VAL),
    .BLANK_IDX(BLANK_IDX), .BLANK_RST(BLANK_RST)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .idx_i  (wr_idx),
    .val_i  (wr_val),
    .act_o  (act),
    .lock_o (locked_o)
  );

  bcd_fields #(
    .NREG(NREG), .HPIX_IDX(HPIX_IDX), .PCLK_IDX(PCLK_IDX), .B16_IDX(B16_IDX),
    .B8_IDX(B8_IDX), .BLANK_IDX(BLANK_IDX)
  ) u_fields (
    .act_i        (act),
    .h_pixels_o   (h_pixels_o),
    .pix_clk_o    (pix_clk_o),
    .base16_o     (base16_o),
    .base8_o      (base8_o),
    .blank_mode_o (blank_mode_o)
  );

  assign regs_o = act;

  assert_idle_no_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !locked_o) |=> $stable(regs_o));
endmodule

// File: tb/tb_bulk_cmd_decoder.sv
module tb_bulk_cmd_decoder;
  localparam int NREG = 64;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [7:0]        byte_i = 8'h00;
  logic              valid_i = 1'b0;
  logic              ready_o;
  logic [NREG*8-1:0] regs_o;
  logic [15:0]       h_pixels_o, pix_clk_o;
  logic [23:0]       base16_o, base8_o;
  logic [7:0]        blank_mode_o;
  logic              locked_o, err_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_act [NREG];
  logic [7:0] m_sh  [NREG];
  logic       m_lock, m_err;

  bulk_cmd_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i),
    .ready_o(ready_o), .regs_o(regs_o), .h_pixels_o(h_pixels_o),
    .pix_clk_o(pix_clk_o), .base16_o(base16_o), .base8_o(base8_o),
    .blank_mode_o(blank_mode_o), .locked_o(locked_o), .err_o(err_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NREG; k++) begin
      m_act[k] = (k == 31) ? 8'h01 : 8'h00;
      m_sh[k]  = m_act[k];
    end
    m_lock = 1'b0;
    m_err  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk_i);
    byte_i  = b;
    valid_i = 1'b1;
    @(posedge clk_i);
  endtask

  task automatic settle();
    @(negedge clk_i);
    valid_i = 1'b0;
    byte_i  = 8'($urandom);
  endtask

  task automatic model_wr(input logic [7:0] idx, input logic [7:0] val);
    if (idx < NREG) begin
      m_sh[idx] = val;
      if (!m_lock) m_act[idx] = val;
    end else if (idx == 8'hFF) begin
      if (val == 8'h00) m_lock = 1'b1;
      else if (val == 8'hFF) begin
        m_lock = 1'b0;
        for (int k = 0; k < NREG; k++) m_act[k] = m_sh[k];
      end
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    put(8'hAF); put(8'h20); put(idx); put(val);
    model_wr(idx, val);
  endtask

  task automatic copy_cmd(input logic [7:0] fill);
    put(8'hAF); put(8'h6A);
    for (int k = 0; k < 7; k++) put((k % 2 == 0) ? fill : 8'($urandom));
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      byte_i  = (k % 2 == 0) ? 8'hAF : 8'h20;
      @(posedge clk_i);
    end
  endtask

  task automatic check_all(input string req);
    settle();
    for (int k = 0; k < NREG; k++) chk(req, 32'(regs_o[k*8 +: 8]), 32'(m_act[k]));
    chk(req, 32'(h_pixels_o), 32'({m_act[15], m_act[16]}));
    chk(req, 32'(pix_clk_o), 32'({m_act[28], m_act[27]}));
    chk(req, 32'(base16_o), 32'({m_act[32], m_act[33], m_act[34]}));
    chk(req, 32'(base8_o), 32'({m_act[38], m_act[39], m_act[40]}));
    chk(req, 32'(blank_mode_o), 32'(m_act[31]));
    chk(req, 32'(locked_o), 32'(m_lock));
    chk(req, 32'(err_o), 32'(m_err));
    chk(req, 32'(ready_o), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    check_all("R1 reset");
    chk("R1 blank", 32'(blank_mode_o), 32'h01);

    wr(8'h05, 8'h5A);
    check_all("R2 open write");
    chk("R2 reg5", 32'(regs_o[5*8 +: 8]), 32'h5A);
    wr(8'h0F, 8'h05); wr(8'h10, 8'h00);
    check_all("R5 hpix");
    chk("R5 hpix", 32'(h_pixels_o), 32'h0500);
    wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
    check_all("R6 pclk");
    chk("R6 pclk", 32'(pix_clk_o), 32'h1234);
    wr(8'h20, 8'hAB); wr(8'h21, 8'hCD); wr(8'h22, 8'hEF);
    wr(8'h26, 8'h01); wr(8'h27, 8'h23); wr(8'h28, 8'h45);
    check_all("R7 bases");
    chk("R7 base16", 32'(base16_o), 32'hABCDEF);
    chk("R7 base8", 32'(base8_o), 32'h012345);

    wr(8'hFF, 8'h00);
    check_all("R3 lock");
    wr(8'h0F, 8'h03); wr(8'h10, 8'h20); wr(8'h1B, 8'h99); wr(8'h22, 8'h00); wr(8'h1F, 8'h00);
    check_all("R3 held");
    chk("R3 hpix held", 32'(h_pixels_o), 32'h0500);
    put(8'hAF); put(8'h20); put(8'hFF);
    check_all("R4 not before");
    put(8'hFF);
    model_wr(8'hFF, 8'hFF);
    check_all("R4 commit");
    chk("R4 hpix", 32'(h_pixels_o), 32'h0320);
    chk("R4 base16", 32'(base16_o), 32'hABCD00);

    copy_cmd(8'hAF);
    copy_cmd(8'h20);
    check_all("R8 copy skipped");
    wr(8'h07, 8'h77);
    check_all("R8 realign");

    put(8'hAF);
    wr(8'h08, 8'h88);
    check_all("R9 padding");

    wr(8'h40, 8'h11); wr(8'h80, 8'h22); wr(8'hFE, 8'h33); wr(8'hFF, 8'h5C);
    check_all("R12 out of range");

    gap(6);
    check_all("R13 valid low");

    put(8'h12); m_err = 1'b1;
    check_all("R10 junk");
    wr(8'h09, 8'h99);
    check_all("R10 resync");
    gap(3);
    check_all("R10 sticky");

    do_reset();
    put(8'hAF); put(8'h33); m_err = 1'b1;
    put(8'h0A); put(8'h55);
    check_all("R11 bad code");
    wr(8'h0A, 8'h66);
    check_all("R11 recover");

    do_reset();
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = int'($urandom % 20);
      if (sel < 10) wr(8'($urandom % NREG), 8'($urandom));
      else if (sel < 12) wr(8'hFF, 8'h00);
      else if (sel < 14) wr(8'hFF, 8'hFF);
      else if (sel == 14) wr(8'hFF, 8'($urandom));
      else if (sel == 15) wr(8'(64 + $urandom % 190), 8'($urandom));
      else if (sel == 16) copy_cmd(8'($urandom));
      else if (sel == 17) put(8'hAF);
      else if (sel == 18) gap(int'($urandom % 4) + 1);
      else if (n > 300) begin put(8'h3C); m_err = 1'b1; end
      if (n % 10 == 9) check_all("R2 R3 R4 R8 R9 R12 R13 random");
    end
    check_all("R4 random final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule